// File: doc/BRIEF.md
# SPI Target Status Poller

This block repeatedly samples the one-byte status word of an SPI target and stops when the target reports the condition the caller is waiting for, when the target flags a fault, or when a time budget runs out. A caller pulses a start strobe together with an 8-bit mask. The block then drives an SPI byte engine. Every sample consists of two separate one-byte transfers that carry the status opcode 0x00. The engine frames each transfer with its own chip-select assertion, so chip select drops between the two. The byte returned by the first transfer is thrown away, because the target may not have refreshed it yet. Only the second byte is judged.

The judged byte decides what happens next. Bit 0 means busy, bit 1 means ready, and bits 2 and 3 are the two fault indications. A fault ends the poll at once with an error. A match ends it with success. In any other case, a new sample starts with no idle gap. A cycle counter started at the accepted start strobe enforces the time budget, whose length comes from a clock-frequency parameter and a millisecond parameter. The budget is checked only after a sample has been judged. When the poll finishes, the block raises a one-cycle done pulse and keeps the final byte and flags visible until the next accepted start.

Top module: `spi_status_poller`

## Requirements
- R1: After reset, done_o, err_o, tmo_o and eng_go_o are 0 and status_o is 0x00.
- R2: Each sample issues exactly two transfer requests, each as a one-cycle eng_go_o pulse with eng_txd_o = 0x00. A new request is issued only after eng_done_i has answered the previous one.
- R3: The byte returned by the first transfer of a sample is ignored. Only the byte of the second transfer is judged and reported.
- R4: A judged byte s with bits 2 and 3 clear ends the poll successfully when (s & (0x01 | mask)) == mask. The mask is the value captured at start, and bit 0 is busy. Success gives done_o with err_o = 0, tmo_o = 0 and status_o = s.
- R5: A judged byte with bit 2 or bit 3 set ends the poll at once with err_o = 1 and tmo_o = 0, even when the success condition also holds.
- R6: When a judged byte neither matches nor faults and time remains, the next sample's first request follows in the cycle right after the eng_done_i that delivered the byte.
- R7: The budget is CLK_HZ/1000*TIMEOUT_MS cycles counted from the accepted start. If a judged byte neither matches nor faults and the budget has elapsed, the poll ends with tmo_o = 1, err_o = 0 and status_o equal to that byte.
- R8: done_o is high for exactly one cycle per poll, and err_o and tmo_o are never both 1.
- R9: status_o, err_o and tmo_o change only together with done_o and then hold until the next poll ends. A start_i pulse while a poll is running is ignored, including its mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mask_i | input | 8 | Status bits that must be set for success, captured at start |
| done_o | output | 1 | One-cycle pulse when a poll ends |
| status_o | output | 8 | Last judged status byte |
| err_o | output | 1 | Poll ended on a fault bit |
| tmo_o | output | 1 | Poll ended on budget expiry |
| eng_go_o | output | 1 | One-cycle request for a one-byte transfer |
| eng_txd_o | output | 8 | Byte to send (status opcode) |
| eng_done_i | input | 1 | Engine pulse: transfer finished, eng_rxd_i valid |
| eng_rxd_i | input | 8 | Byte received in the finished transfer |

## Verification
The in-design checks assume that the byte engine answers each request with exactly one eng_done_i pulse, never in the same cycle as the request, and never without a pending request. The bench models the engine with a fixed three-cycle latency and one outstanding transfer, and it records any request that arrives while one is pending. Start strobes are one cycle wide and are driven away from clock edges. The ignored-start case deliberately pulses start_i in the middle of a running poll, which the design must tolerate.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;

    localparam int          STAT_W     = 8;
    localparam int          BUSY_BIT   = 0;
    localparam int          VIOL_BIT   = 2;
    localparam int          FAULT_BIT  = 3;
    localparam logic [7:0]  OPC_STATUS = 8'h00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE_A,
        S_WAIT_A,
        S_ISSUE_B,
        S_WAIT_B
    } seq_state_e;

    typedef enum logic [1:0] {
        V_RETRY,
        V_MATCH,
        V_FAULT
    } verdict_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              err;
        logic              tmo;
    } result_t;

    function automatic verdict_e judge_status(input logic [STAT_W-1:0] s,
                                              input logic [STAT_W-1:0] m);
        logic [STAT_W-1:0] sel;
        sel = m;
        sel[BUSY_BIT] = 1'b1;
        if (s[VIOL_BIT] || s[FAULT_BIT])
            return V_FAULT;
        else if ((s & sel) == m)
            return V_MATCH;
        else
            return V_RETRY;
    endfunction

endpackage

// File: rtl/poll_judge.sv
module poll_judge
    import spi_poll_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    input  logic [STAT_W-1:0] mask_i,
    output verdict_e          verdict_o
);
    always_comb verdict_o = judge_status(stat_i, mask_i);
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (clear_i)
            count_q <= '0;
        else if (run_i && count_q < LIM)
            count_q <= count_q + 1'b1;
    end

    assign expired_o = (count_q >= LIM);

    assert_count_sat_R7: assert property (@(posedge clk) disable iff (rst)
        expired_o && !clear_i |=> expired_o);
endmodule

// File: rtl/poll_seq.sv
module poll_seq
    import spi_poll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     eng_done_i,
    input  verdict_e verdict_i,
    input  logic     expired_i,
    output logic     accept_o,
    output logic     busy_o,
    output logic     eng_go_o,
    output logic     finish_o,
    output logic     fin_err_o,
    output logic     fin_tmo_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        accept_o  = 1'b0;
        finish_o  = 1'b0;
        fin_err_o = 1'b0;
        fin_tmo_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    state_d  = S_ISSUE_A;
                end
            end
            S_ISSUE_A: state_d = S_WAIT_A;
            S_WAIT_A:  if (eng_done_i) state_d = S_ISSUE_B;
            S_ISSUE_B: state_d = S_WAIT_B;
            S_WAIT_B: begin
                if (eng_done_i) begin
                    if (verdict_i == V_FAULT) begin
                        finish_o  = 1'b1;
                        fin_err_o = 1'b1;
                        state_d   = S_IDLE;
                    end else if (verdict_i == V_MATCH) begin
                        finish_o  = 1'b1;
                        state_d   = S_IDLE;
                    end else if (expired_i) begin
                        finish_o  = 1'b1;
                        fin_tmo_o = 1'b1;
                        state_d   = S_IDLE;
                    end else begin
                        state_d   = S_ISSUE_A;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign eng_go_o = (state_q == S_ISSUE_A) || (state_q == S_ISSUE_B);
    assign busy_o   = (state_q != S_IDLE);

    assert_go_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        eng_go_o |=> !eng_go_o);

    assert_no_go_in_flight_R2: assert property (@(posedge clk) disable iff (rst)
        eng_go_o |=> !eng_go_o until_with eng_done_i);
endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller
    import spi_poll_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int unsigned TIMEOUT_MS = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  mask_i,
    output logic        done_o,
    output logic [7:0]  status_o,
    output logic        err_o,
    output logic        tmo_o,
    output logic        eng_go_o,
    output logic [7:0]  eng_txd_o,
    input  logic        eng_done_i,
    input  logic [7:0]  eng_rxd_i
);
    localparam int unsigned BUDGET = (CLK_HZ / 1000) * TIMEOUT_MS;

    logic [STAT_W-1:0] mask_q;
    verdict_e          verdict;
    logic              accept, busy, expired;
    logic              finish, fin_err, fin_tmo;
    result_t           res_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst)         mask_q <= '0;
        else if (accept) mask_q <= mask_i;
    end

    poll_judge u_judge (
        .stat_i    (eng_rxd_i),
        .mask_i    (mask_q),
        .verdict_o (verdict)
    );

    poll_timer #(.LIMIT(BUDGET)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (accept),
        .run_i     (busy),
        .expired_o (expired)
    );

    poll_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .eng_done_i (eng_done_i),
        .verdict_i  (verdict),
        .expired_i  (expired),
        .accept_o   (accept),
        .busy_o     (busy),
        .eng_go_o   (eng_go_o),
        .finish_o   (finish),
        .fin_err_o  (fin_err),
        .fin_tmo_o  (fin_tmo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                res_q.stat <= eng_rxd_i;
                res_q.err  <= fin_err;
                res_q.tmo  <= fin_tmo;
            end
        end
    end

    assign eng_txd_o = OPC_STATUS;
    assign done_o    = done_q;
    assign status_o  = res_q.stat;
    assign err_o     = res_q.err;
    assign tmo_o     = res_q.tmo;

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(err_o && tmo_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_q) |-> done_o);

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
        done_o && err_o |-> (status_o[VIOL_BIT] || status_o[FAULT_BIT]));

    assert_tmo_after_budget_R7: assert property (@(posedge clk) disable iff (rst)
        done_o && tmo_o |-> expired);

    assert_ok_no_busy_R4: assert property (@(posedge clk) disable iff (rst)
        done_o && !err_o && !tmo_o && !mask_q[BUSY_BIT] |-> !status_o[BUSY_BIT]);
endmodule

// File: tb/tb_spi_status_poller.sv
module tb_spi_status_poller;
    localparam int LAT   = 3;
    localparam int LIMIT = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] mask_i = 8'h00;
    logic       done_o, err_o, tmo_o, eng_go_o;
    logic [7:0] status_o, eng_txd_o;
    logic       eng_done = 1'b0;
    logic [7:0] eng_rxd = 8'h00;

    always #4 clk = ~clk;

    spi_status_poller #(.CLK_HZ(100_000), .TIMEOUT_MS(2)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mask_i(mask_i),
        .done_o(done_o), .status_o(status_o), .err_o(err_o), .tmo_o(tmo_o),
        .eng_go_o(eng_go_o), .eng_txd_o(eng_txd_o),
        .eng_done_i(eng_done), .eng_rxd_i(eng_rxd)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] resp [0:31];
    int rn = 0, ridx = 0;
    logic [7:0] dflt = 8'h01;
    int n_go = 0, bad_op = 0, overlap = 0, max_gap = 0, last_done = 0;
    int pend = 0, cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            eng_done <= 1'b0;
            pend = 0;
        end else begin
            eng_done <= 1'b0;
            if (eng_done) last_done = cyc;
            if (pend != 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    pend = 0;
                    eng_done <= 1'b1;
                    eng_rxd  <= (ridx < rn) ? resp[ridx] : dflt;
                    ridx = ridx + 1;
                end
            end
            if (eng_go_o) begin
                n_go = n_go + 1;
                if (eng_txd_o != 8'h00) bad_op = bad_op + 1;
                if (pend != 0) overlap = overlap + 1;
                if (n_go > 1 && cyc - last_done > max_gap) max_gap = cyc - last_done;
                pend = 1;
                cnt  = LAT;
            end
        end
        cyc = cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3,
                        input logic [7:0] b4, input logic [7:0] b5, input int n);
        resp[0] = b0; resp[1] = b1; resp[2] = b2;
        resp[3] = b3; resp[4] = b4; resp[5] = b5;
        rn = n; ridx = 0; n_go = 0; bad_op = 0; overlap = 0; max_gap = 0;
    endtask

    // Runs one poll; optionally pulses start with mask 0x00 mid-run.
    task automatic run_poll(input logic [7:0] m, input bit poke,
                            output logic [7:0] st, output bit e, output bit t,
                            output int dur, output bit single);
        int t0, k;
        @(negedge clk);
        mask_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; mask_i = 8'h00;
        t0 = cyc;
        k = 0;
        while (!done_o && k < 3000) begin
            if (poke && k == 4) start_i = 1'b1;
            else start_i = 1'b0;
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        dur = cyc - t0;
        st = status_o; e = err_o; t = tmo_o;
        @(negedge clk);
        single = !done_o;
    endtask

    task automatic t_reset;
        check(done_o == 0 && err_o == 0 && tmo_o == 0, "R1", "flags", {done_o, err_o, tmo_o}, 0);
        check(status_o == 8'h00, "R1", "status", status_o, 0);
        check(eng_go_o == 0, "R1", "eng_go", eng_go_o, 0);
    endtask

    task automatic t_first_discard;
        logic [7:0] st; bit e, t, s; int d;
        load(8'h0C, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 2);
        run_poll(8'h02, 0, st, e, t, d, s);
        check(st == 8'h02 && !e && !t, "R3", "first byte must be dropped", st, 8'h02);
        check(n_go == 2, "R2", "requests per sample", n_go, 2);
        check(bad_op == 0, "R2", "opcode not 0x00", bad_op, 0);
        check(s, "R8", "done width", s, 1);
    endtask

    task automatic t_retry_then_ok;
        logic [7:0] st; bit e, t, s; int d;
        load(8'h02, 8'h01, 8'h00, 8'h03, 8'h00, 8'h02, 6);
        run_poll(8'h02, 0, st, e, t, d, s);
        check(st == 8'h02 && !e && !t, "R4", "success after busy", st, 8'h02);
        check(n_go == 6, "R6", "requests over three samples", n_go, 6);
        check(max_gap == 1, "R6", "gap after done", max_gap, 1);
        check(overlap == 0, "R2", "request while pending", overlap, 0);
    endtask

    task automatic t_mask_variants;
        logic [7:0] st; bit e, t, s; int d;
        load(8'h00, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 2);
        run_poll(8'h00, 0, st, e, t, d, s);
        check(st == 8'hF0 && !e && !t, "R4", "mask 0 idle byte", st, 8'hF0);
        load(8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 2);
        run_poll(8'h03, 0, st, e, t, d, s);
        check(st == 8'h03 && !e && !t && n_go == 2, "R4", "mask with busy bit", st, 8'h03);
    endtask

    task automatic t_fault;
        logic [7:0] st; bit e, t, s; int d;
        load(8'h00, 8'h04, 8'h00, 8'h02, 8'h00, 8'h00, 4);
        run_poll(8'h00, 0, st, e, t, d, s);
        check(st == 8'h04 && e && !t && n_go == 2, "R5", "violation bit", st, 8'h04);
        load(8'h00, 8'h0A, 8'h00, 8'h02, 8'h00, 8'h00, 4);
        run_poll(8'h02, 0, st, e, t, d, s);
        check(st == 8'h0A && e && !t, "R5", "fault beats match", st, 8'h0A);
        check(n_go == 2, "R5", "ends at once", n_go, 2);
    endtask

    task automatic t_timeout;
        logic [7:0] st; bit e, t, s; int d;
        load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        dflt = 8'h01;
        run_poll(8'h00, 0, st, e, t, d, s);
        check(t && !e && st == 8'h01, "R7", "timeout flags/status", {e, t}, 1);
        check(d >= LIMIT && d <= LIMIT + 24, "R7", "timeout latency", d, LIMIT);
        check(!(e && t) && s, "R8", "exclusive and single pulse", {e, t, s}, 1);
        repeat (20) @(negedge clk);
        check(status_o == 8'h01 && tmo_o && !err_o && !done_o, "R9", "hold after done",
              {status_o, tmo_o, err_o, done_o}, {8'h01, 3'b100});
    endtask

    task automatic t_ignore_start;
        logic [7:0] st; bit e, t, s; int d;
        load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 6);
        run_poll(8'h02, 1, st, e, t, d, s);
        check(st == 8'h02 && !e && !t, "R9", "mid-run start ignored", st, 8'h02);
        check(n_go == 6, "R9", "requests with ignored start", n_go, 6);
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_discard();
        t_retry_then_ok();
        t_mask_variants();
        t_fault();
        t_timeout();
        t_ignore_start();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=0x1 expected=0x0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule